// File: doc/BRIEF.md
# Operand Effective Address Generator with Prefix Remapping

This block computes the effective address of the memory operand for a small 8-bit core with a 16-bit address space. Each instruction reaches it as one `go` pulse. With the pulse come an optional prefix byte, the addressing mode chosen by the opcode, a flag that marks a one-operand instruction, a flag that marks write-back to the memory operand, up to two operand bytes, and the X and Y index values. Modes that need no memory access finish in the same cycle as `go`.

A prefix byte can change the mode in two ways. It can move every use of X, including the X-register operand, onto Y. It can also insert an indirection step. In that step the operand byte becomes the zero-page address of a pointer. The block reads that pointer through a one-outstanding request/valid port. A 16-bit pointer is stored high byte first. The pointer is then used directly, or an index is added to it.

Illegal mixes of instruction class, mode, prefix and write-back are reported through a flag. No memory read is issued for them. The result is returned with a one-cycle ready strobe.

Top module: `ea_gen`

## Requirements
- R1: Mode codes are 0 immediate, 1 8-bit absolute, 2 16-bit absolute, 3 indexed, 4 indexed plus 8-bit offset, 5 indexed plus 16-bit offset, 6 accumulator, 7 X register. Without indirection, 8-bit absolute gives {0x00,op_lo}, 16-bit absolute gives {op_hi,op_lo}, and indexed gives the zero-extended index, all with `ea_ready` in the cycle of `go`.
- R2: Index plus offset is a full 16-bit addition, so 0xFF plus an 8-bit offset of 0xFF gives 0x01FE. A 16-bit offset plus an index wraps modulo 65536.
- R3: Prefix 0x90 replaces X by Y in every indexed mode and in the X-register mode. `ea_use_y` reports the swap with `ea_ready`.
- R4: Prefix 0x92 with 8-bit absolute issues exactly one read, at {0x00,op_lo}. It yields EA = {0x00,data}, with `ea_ready` one cycle after the `mem_rvalid` cycle.
- R5: Indirection through a 16-bit pointer (mode 2 or 5) reads zero-page byte p and then byte p+1 modulo 256. The first byte returned is the high byte. `ea_ready` comes one cycle after the second `mem_rvalid`.
- R6: Indirection with mode 4 or 5 adds the index to the pointer modulo 65536. The index is X under 0x92 and Y under prefix 0x91.
- R7: Immediate mode asserts `ea_imm` with `ea_ready` in the cycle of `go`, issues no read, and drives EA 0. Immediate with write-back is illegal.
- R8: Illegal combinations assert `ea_illegal` and `ea_ready` in the cycle of `go`, with EA 0 and no read. They are: a one-operand instruction with mode 0, 2 or 5; a two-operand instruction with mode 6 or 7; indirection with mode 0, 3, 6 or 7; immediate with write-back.
- R9: Modes 6 and 7 in a one-operand instruction assert `ea_reg` with `ea_ready` in the cycle of `go`. At most one of `ea_imm`, `ea_reg` and `ea_illegal` is high, and each is high only with `ea_ready`.
- R10: A `go` that arrives while an indirection is in progress is ignored. It issues no read, produces no ready and leaves the pending result unchanged.
- R11: During and after reset, with no `go`, `mem_req` and `ea_ready` are low.
- R12: A prefix byte other than 0x90, 0x91 or 0x92 acts as no prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start of one address computation |
| prefix | input | 8 | Prefix byte, or any other value for none |
| mode | input | 3 | Addressing mode code |
| one_op | input | 1 | One-operand instruction |
| wr_back | input | 1 | Result is written to the memory operand |
| op_lo | input | 8 | First operand byte (low address or pointer location) |
| op_hi | input | 8 | Second operand byte (high address) |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| mem_req | output | 1 | Pointer byte read request, one cycle |
| mem_addr | output | 16 | Pointer byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| ea_ready | output | 1 | Result strobe |
| ea | output | 16 | Effective address |
| ea_imm | output | 1 | Operand is the immediate byte |
| ea_reg | output | 1 | Operand is a register |
| ea_use_y | output | 1 | X references were moved to Y |
| ea_illegal | output | 1 | Illegal combination |

## Verification
The bench builds the block with 16-bit addresses, 8-bit data, the default prefix codes and wrapping of the pointer's second byte inside the zero page. With these values, a pointer at 0xFF wraps to 0x00, and 0xFF plus 0xFF reaches 0x01FE. The bench's memory model answers each read two cycles after the request, so the wait states are visible. The same delay leaves room to send a second `go` while a two-byte pointer fetch is still pending.

// File: rtl/eag_pkg.sv
package eag_pkg;

   typedef enum logic [2:0] {
      AM_IMM8      = 3'd0,
      AM_ABS8      = 3'd1,
      AM_ABS16     = 3'd2,
      AM_IDX       = 3'd3,
      AM_IDX_OFF8  = 3'd4,
      AM_IDX_OFF16 = 3'd5,
      AM_ACC       = 3'd6,
      AM_XREG      = 3'd7
   } am_e;

   typedef struct packed {
      logic illegal;
      logic indirect;
      logic use_y;
      logic ptr16;
      logic add_idx;
      logic imm;
      logic reg_op;
   } eag_ctl_t;

endpackage

// File: rtl/eag_decode.sv
module eag_decode
   import eag_pkg::*;
#(
   parameter int            DW       = 8,
   parameter logic [DW-1:0] PFX_SWAP = 'h90,
   parameter logic [DW-1:0] PFX_IND  = 'h92,
   parameter logic [DW-1:0] PFX_BOTH = 'h91
) (
   input  logic [DW-1:0] prefix,
   input  logic [2:0]    mode,
   input  logic          one_op,
   input  logic          wr_back,
   output eag_ctl_t      ctl
);

   am_e  am;
   logic swap, ind;
   logic ok_one, ok_two, ind_ok;
   logic is_imm, is_reg, wide, indexed, bad;

   assign am   = am_e'(mode);
   assign swap = (prefix == PFX_SWAP) || (prefix == PFX_BOTH);
   assign ind  = (prefix == PFX_IND)  || (prefix == PFX_BOTH);

   always_comb begin
      ok_one  = 1'b0;
      ok_two  = 1'b0;
      ind_ok  = 1'b0;
      is_imm  = 1'b0;
      is_reg  = 1'b0;
      wide    = 1'b0;
      indexed = 1'b0;
      case (am)
         AM_IMM8: begin
            ok_two = 1'b1;
            is_imm = 1'b1;
         end
         AM_ABS8: begin
            ok_one = 1'b1;
            ok_two = 1'b1;
            ind_ok = 1'b1;
         end
         AM_ABS16: begin
            ok_two = 1'b1;
            ind_ok = 1'b1;
            wide   = 1'b1;
         end
         AM_IDX: begin
            ok_one  = 1'b1;
            ok_two  = 1'b1;
            indexed = 1'b1;
         end
         AM_IDX_OFF8: begin
            ok_one  = 1'b1;
            ok_two  = 1'b1;
            ind_ok  = 1'b1;
            indexed = 1'b1;
         end
         AM_IDX_OFF16: begin
            ok_two  = 1'b1;
            ind_ok  = 1'b1;
            wide    = 1'b1;
            indexed = 1'b1;
         end
         AM_ACC, AM_XREG: begin
            ok_one = 1'b1;
            is_reg = 1'b1;
         end
         default: begin
            ok_one = 1'b0;
         end
      endcase
   end

   assign bad = (one_op ? !ok_one : !ok_two)
              || (ind && !ind_ok)
              || (is_imm && wr_back);

   always_comb begin
      ctl          = '0;
      ctl.illegal  = bad;
      ctl.indirect = ind && !bad;
      ctl.use_y    = swap && !bad;
      ctl.ptr16    = ind && wide && !bad;
      ctl.add_idx  = indexed && !bad;
      ctl.imm      = is_imm && !bad;
      ctl.reg_op   = is_reg && !bad;
   end

endmodule

// File: rtl/eag_walk.sv
module eag_walk #(
   parameter int AW      = 16,
   parameter int DW      = 8,
   parameter bit ZP_WRAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ptr16,
   input  logic [DW-1:0] ptr_at,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] ptr_val
);

   localparam int HI_PAD = AW - DW;

   typedef enum logic [2:0] {
      W_IDLE, W_WAIT0, W_ISSUE1, W_WAIT1, W_DONE
   } wst_e;

   wst_e          st_q, st_d;
   logic [DW-1:0] at_q, hi_q, lo_q;
   logic          wide_q;
   logic [AW-1:0] next_addr;

   generate
      if (ZP_WRAP) begin : g_zp_wrap
         assign next_addr = {{HI_PAD{1'b0}}, at_q + DW'(1)};
      end else begin : g_full_inc
         assign next_addr = {{HI_PAD{1'b0}}, at_q} + AW'(1);
      end
   endgenerate

   always_comb begin
      st_d     = st_q;
      mem_req  = 1'b0;
      mem_addr = '0;
      case (st_q)
         W_IDLE: begin
            if (start) begin
               mem_req  = 1'b1;
               mem_addr = {{HI_PAD{1'b0}}, ptr_at};
               st_d     = W_WAIT0;
            end
         end
         W_WAIT0: begin
            if (mem_rvalid) st_d = wide_q ? W_ISSUE1 : W_DONE;
         end
         W_ISSUE1: begin
            mem_req  = 1'b1;
            mem_addr = next_addr;
            st_d     = W_WAIT1;
         end
         W_WAIT1: begin
            if (mem_rvalid) st_d = W_DONE;
         end
         W_DONE:  st_d = W_IDLE;
         default: st_d = W_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= W_IDLE;
         at_q   <= '0;
         hi_q   <= '0;
         lo_q   <= '0;
         wide_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == W_IDLE && start) begin
            at_q   <= ptr_at;
            wide_q <= ptr16;
            hi_q   <= '0;
            lo_q   <= '0;
         end
         if (st_q == W_WAIT0 && mem_rvalid) begin
            if (wide_q) hi_q <= mem_rdata;
            else        lo_q <= mem_rdata;
         end
         if (st_q == W_WAIT1 && mem_rvalid) lo_q <= mem_rdata;
      end
   end

   assign busy    = (st_q != W_IDLE);
   assign done    = (st_q == W_DONE);
   assign ptr_val = AW'({hi_q, lo_q});

endmodule

// File: rtl/eag_index_add.sv
module eag_index_add #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] idx,
   input  logic          en,
   output logic [AW-1:0] sum
);

   localparam int PAD = AW - DW;

   logic [AW-1:0] idx_ext;

   generate
      if (PAD > 0) begin : g_pad
         assign idx_ext = en ? {{PAD{1'b0}}, idx} : '0;
      end else begin : g_nopad
         assign idx_ext = en ? idx[AW-1:0] : '0;
      end
   endgenerate

   assign sum = base + idx_ext;

endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import eag_pkg::*;
#(
   parameter int            AW       = 16,
   parameter int            DW       = 8,
   parameter logic [DW-1:0] PFX_SWAP = 'h90,
   parameter logic [DW-1:0] PFX_IND  = 'h92,
   parameter logic [DW-1:0] PFX_BOTH = 'h91,
   parameter bit            ZP_WRAP  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] prefix,
   input  logic [2:0]    mode,
   input  logic          one_op,
   input  logic          wr_back,
   input  logic [DW-1:0] op_lo,
   input  logic [DW-1:0] op_hi,
   input  logic [DW-1:0] idx_x,
   input  logic [DW-1:0] idx_y,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata,
   output logic          ea_ready,
   output logic [AW-1:0] ea,
   output logic          ea_imm,
   output logic          ea_reg,
   output logic          ea_use_y,
   output logic          ea_illegal
);

   localparam int HI_PAD = AW - DW;

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("ea_gen: AW must be twice DW to hold a two-byte pointer");
      end
      if (PFX_SWAP == PFX_IND || PFX_SWAP == PFX_BOTH || PFX_IND == PFX_BOTH) begin : g_bad_pfx
         $error("ea_gen: prefix codes must be distinct");
      end
   endgenerate

   eag_ctl_t      ctl;
   logic          walk_busy, walk_done, walk_start;
   logic          fire, direct_fire, addr_out_ok;
   logic [AW-1:0] ptr_val, base_direct, add_base, sum;
   logic [DW-1:0] idx_now, idx_q, add_idx_v;
   logic          add_q, use_y_q, add_en;
   am_e           am;

   eag_decode #(
      .DW       (DW),
      .PFX_SWAP (PFX_SWAP),
      .PFX_IND  (PFX_IND),
      .PFX_BOTH (PFX_BOTH)
   ) u_dec (
      .prefix  (prefix),
      .mode    (mode),
      .one_op  (one_op),
      .wr_back (wr_back),
      .ctl     (ctl)
   );

   assign fire        = go && !walk_busy;
   assign direct_fire = fire && (ctl.illegal || !ctl.indirect);
   assign walk_start  = fire && ctl.indirect;

   eag_walk #(
      .AW      (AW),
      .DW      (DW),
      .ZP_WRAP (ZP_WRAP)
   ) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (walk_start),
      .ptr16      (ctl.ptr16),
      .ptr_at     (op_lo),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .busy       (walk_busy),
      .done       (walk_done),
      .ptr_val    (ptr_val)
   );

   assign am      = am_e'(mode);
   assign idx_now = ctl.use_y ? idx_y : idx_x;

   always_comb begin
      case (am)
         AM_ABS8, AM_IDX_OFF8:   base_direct = {{HI_PAD{1'b0}}, op_lo};
         AM_ABS16, AM_IDX_OFF16: base_direct = AW'({op_hi, op_lo});
         default:                base_direct = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         add_q   <= 1'b0;
         use_y_q <= 1'b0;
      end else if (walk_start) begin
         idx_q   <= idx_now;
         add_q   <= ctl.add_idx;
         use_y_q <= ctl.use_y;
      end
   end

   assign add_base  = walk_done ? ptr_val : base_direct;
   assign add_idx_v = walk_done ? idx_q : idx_now;
   assign add_en    = walk_done ? add_q : ctl.add_idx;

   eag_index_add #(
      .AW (AW),
      .DW (DW)
   ) u_add (
      .base (add_base),
      .idx  (add_idx_v),
      .en   (add_en),
      .sum  (sum)
   );

   assign addr_out_ok = walk_done
                      || (direct_fire && !ctl.illegal && !ctl.imm && !ctl.reg_op);

   assign ea_ready   = direct_fire || walk_done;
   assign ea         = addr_out_ok ? sum : '0;
   assign ea_imm     = direct_fire && ctl.imm;
   assign ea_reg     = direct_fire && ctl.reg_op;
   assign ea_illegal = direct_fire && ctl.illegal;
   assign ea_use_y   = walk_done ? use_y_q : (direct_fire && ctl.use_y);

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_rvalid,
   input logic          ea_ready,
   input logic [AW-1:0] ea,
   input logic          ea_imm,
   input logic          ea_reg,
   input logic          ea_use_y,
   input logic          ea_illegal
);

   logic          pend, data_seen;
   logic [DW-1:0] last_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         data_seen <= 1'b0;
         last_lo   <= '0;
      end else begin
         if (mem_req) begin
            pend    <= 1'b1;
            last_lo <= mem_addr[DW-1:0];
         end else if (ea_ready) begin
            pend <= 1'b0;
         end
         if (mem_req)         data_seen <= 1'b0;
         else if (mem_rvalid) data_seen <= 1'b1;
      end
   end

   AST_FIRST_READ_ZERO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !pend |-> mem_addr[AW-1:DW] == '0);                       // R4
   AST_SECOND_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && pend |-> mem_addr[DW-1:0] == last_lo + DW'(1));            // R5
   AST_READY_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ea_ready && pend |-> data_seen);                                      // R4
   AST_IMM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ea_imm |-> ea_ready && !mem_req && ea == '0);                         // R7
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ea_illegal |-> !mem_req && ea == '0 && !pend);                        // R8
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ea_ready |-> $countones({ea_imm, ea_reg, ea_illegal}) <= 1);          // R9
   AST_FLAGS_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_imm || ea_reg || ea_illegal || ea_use_y) |-> ea_ready);           // R9
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);                                                // R10
   AST_NO_READY_WHILE_ISSUING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ea_ready);                                               // R10

endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .ea_ready   (ea_ready),
   .ea         (ea),
   .ea_imm     (ea_imm),
   .ea_reg     (ea_reg),
   .ea_use_y   (ea_use_y),
   .ea_illegal (ea_illegal)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
   import eag_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int RESP_LAT   = 2;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [7:0]  prefix = '0;
   logic [2:0]  mode = '0;
   logic        one_op = 1'b0;
   logic        wr_back = 1'b0;
   logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        ea_ready;
   logic [15:0] ea;
   logic        ea_imm, ea_reg, ea_use_y, ea_illegal;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ea_gen uut (
      .clk(clk), .rst_n(rst_n), .go(go), .prefix(prefix), .mode(mode),
      .one_op(one_op), .wr_back(wr_back), .op_lo(op_lo), .op_hi(op_hi),
      .idx_x(idx_x), .idx_y(idx_y), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ea_ready(ea_ready),
      .ea(ea), .ea_imm(ea_imm), .ea_reg(ea_reg), .ea_use_y(ea_use_y),
      .ea_illegal(ea_illegal)
   );

   function automatic logic [7:0] mb(input logic [15:0] a);
      return (a[7:0] ^ 8'hA5) + 8'd3;
   endfunction

   int          resp_cnt = 0;
   logic [15:0] resp_addr = '0;

   always @(negedge clk) begin
      mem_rvalid <= 1'b0;
      if (resp_cnt != 0) begin
         resp_cnt <= resp_cnt - 1;
         if (resp_cnt == 1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mb(resp_addr);
         end
      end
      if (mem_req) begin
         resp_addr <= mem_addr;
         resp_cnt  <= RESP_LAT;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // flags order: {illegal, imm, reg, use_y}
   task automatic run(input string req, input logic [7:0] pfx, input am_e md,
                      input logic one, input logic wb,
                      input logic [7:0] lo, input logic [7:0] hi,
                      input logic [7:0] x, input logic [7:0] y,
                      input logic [15:0] x_ea, input logic [3:0] x_fl,
                      input int x_reads, input logic [15:0] x_a0,
                      input logic [15:0] x_a1, input int x_cyc, input bit poke);
      int          reads = 0;
      int          cyc = -1;
      logic [15:0] a0 = '0, a1 = '0, got_ea = '0;
      logic [3:0]  got_fl = '0;
      @(posedge clk); #1;
      prefix = pfx; mode = md; one_op = one; wr_back = wb;
      op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; go = 1'b1;
      for (int c = 0; c < 40 && cyc < 0; c++) begin
         @(negedge clk);
         if (mem_req) begin
            if (reads == 0) a0 = mem_addr;
            else            a1 = mem_addr;
            reads++;
         end
         if (ea_ready) begin
            cyc    = c;
            got_ea = ea;
            got_fl = {ea_illegal, ea_imm, ea_reg, ea_use_y};
         end
         @(posedge clk); #1;
         if (poke && c == 0) begin
            go = 1'b1; prefix = 8'h00; mode = AM_ABS8; op_lo = 8'h77;
         end else begin
            go = 1'b0;
         end
      end
      go = 1'b0;
      check(req, "ready cycle", cyc, x_cyc);
      check(req, "ea", got_ea, x_ea);
      check(req, "flags", got_fl, x_fl);
      check(req, "read count", reads, x_reads);
      if (x_reads >= 1) check(req, "first read addr", a0, x_a0);
      if (x_reads >= 2) check(req, "second read addr", a1, x_a1);
   endtask

   task automatic t_reset;
      repeat (3) begin
         @(negedge clk);
         check("R11", "mem_req in reset", mem_req, 0);
         check("R11", "ea_ready in reset", ea_ready, 0);
      end
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (2) begin
         @(negedge clk);
         check("R11", "mem_req idle", mem_req, 0);
         check("R11", "ea_ready idle", ea_ready, 0);
      end
   endtask

   task automatic t_direct;   // R1
      run("R1", 8'h00, AM_ABS8,  1'b0, 1'b0, 8'h34, 8'h00, 8'h00, 8'h00, 16'h0034, 4'b0000, 0, 0, 0, 0, 0);
      run("R1", 8'h00, AM_ABS16, 1'b0, 1'b1, 8'h34, 8'h12, 8'h00, 8'h00, 16'h1234, 4'b0000, 0, 0, 0, 0, 0);
      run("R1", 8'h00, AM_IDX,   1'b1, 1'b1, 8'h00, 8'h00, 8'h7F, 8'h11, 16'h007F, 4'b0000, 0, 0, 0, 0, 0);
   endtask

   task automatic t_fullwidth;   // R2
      run("R2", 8'h00, AM_IDX_OFF8,  1'b1, 1'b0, 8'hFF, 8'h00, 8'hFF, 8'h00, 16'h01FE, 4'b0000, 0, 0, 0, 0, 0);
      run("R2", 8'h00, AM_IDX_OFF16, 1'b0, 1'b0, 8'hF0, 8'hFF, 8'h20, 8'h00, 16'h0010, 4'b0000, 0, 0, 0, 0, 0);
   endtask

   task automatic t_swap;   // R3
      run("R3", 8'h90, AM_IDX,      1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 8'h44, 16'h0044, 4'b0001, 0, 0, 0, 0, 0);
      run("R3", 8'h90, AM_IDX_OFF8, 1'b1, 1'b0, 8'h05, 8'h00, 8'h01, 8'h10, 16'h0015, 4'b0001, 0, 0, 0, 0, 0);
      run("R3", 8'h90, AM_XREG,     1'b1, 1'b1, 8'h00, 8'h00, 8'h01, 8'h10, 16'h0000, 4'b0011, 0, 0, 0, 0, 0);
   endtask

   task automatic t_ind8;   // R4
      run("R4", 8'h92, AM_ABS8, 1'b0, 1'b0, 8'h40, 8'h00, 8'h00, 8'h00,
          {8'h00, mb(16'h0040)}, 4'b0000, 1, 16'h0040, 0, RESP_LAT + 1, 0);
   endtask

   task automatic t_ind16;   // R5
      run("R5", 8'h92, AM_ABS16, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00,
          {mb(16'h00FF), mb(16'h0000)}, 4'b0000, 2, 16'h00FF, 16'h0000, 2 * RESP_LAT + 2, 0);
   endtask

   task automatic t_ind_idx;   // R6 (second call also exercises R10)
      run("R6", 8'h92, AM_IDX_OFF8, 1'b0, 1'b0, 8'h10, 8'h00, 8'hF0, 8'h01,
          16'({8'h00, mb(16'h0010)} + 16'h00F0), 4'b0000, 1, 16'h0010, 0, RESP_LAT + 1, 0);
      run("R10", 8'h91, AM_IDX_OFF16, 1'b0, 1'b1, 8'h20, 8'h00, 8'h01, 8'h80,
          16'({mb(16'h0020), mb(16'h0021)} + 16'h0080), 4'b0001, 2, 16'h0020, 16'h0021,
          2 * RESP_LAT + 2, 1);
   endtask

   task automatic t_imm;   // R7
      run("R7", 8'h00, AM_IMM8, 1'b0, 1'b0, 8'h5A, 8'h00, 8'h00, 8'h00, 16'h0000, 4'b0100, 0, 0, 0, 0, 0);
      run("R7", 8'h00, AM_IMM8, 1'b0, 1'b1, 8'h5A, 8'h00, 8'h00, 8'h00, 16'h0000, 4'b1000, 0, 0, 0, 0, 0);
   endtask

   task automatic t_illegal;   // R8
      run("R8", 8'h00, AM_ABS16,     1'b1, 1'b0, 8'h12, 8'h34, 8'h00, 8'h00, 16'h0000, 4'b1000, 0, 0, 0, 0, 0);
      run("R8", 8'h00, AM_IDX_OFF16, 1'b1, 1'b0, 8'h12, 8'h34, 8'h01, 8'h00, 16'h0000, 4'b1000, 0, 0, 0, 0, 0);
      run("R8", 8'h00, AM_ACC,       1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 4'b1000, 0, 0, 0, 0, 0);
      run("R8", 8'h92, AM_IDX,       1'b0, 1'b0, 8'h30, 8'h00, 8'h05, 8'h00, 16'h0000, 4'b1000, 0, 0, 0, 0, 0);
      run("R8", 8'h91, AM_IMM8,      1'b0, 1'b0, 8'h30, 8'h00, 8'h00, 8'h00, 16'h0000, 4'b1000, 0, 0, 0, 0, 0);
      run("R8", 8'h92, AM_XREG,      1'b1, 1'b0, 8'h30, 8'h00, 8'h00, 8'h00, 16'h0000, 4'b1000, 0, 0, 0, 0, 0);
   endtask

   task automatic t_reg;   // R9
      run("R9", 8'h00, AM_ACC,  1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 4'b0010, 0, 0, 0, 0, 0);
      run("R9", 8'h00, AM_XREG, 1'b1, 1'b0, 8'h00, 8'h00, 8'h09, 8'h00, 16'h0000, 4'b0010, 0, 0, 0, 0, 0);
   endtask

   task automatic t_foreign_prefix;   // R12
      run("R12", 8'h55, AM_IDX,  1'b0, 1'b0, 8'h00, 8'h00, 8'h12, 8'h34, 16'h0012, 4'b0000, 0, 0, 0, 0, 0);
      run("R12", 8'h93, AM_ABS8, 1'b0, 1'b0, 8'h66, 8'h00, 8'h12, 8'h34, 16'h0066, 4'b0000, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_direct();
      t_fullwidth();
      t_swap();
      t_ind8();
      t_ind16();
      t_ind_idx();
      t_imm();
      t_illegal();
      t_reg();
      t_foreign_prefix();
      repeat (3) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule